// File: doc/BRIEF.md
# Slave Sync Field Detector

This block sits behind the external sync inputs of a composite video encoder running as a timing slave. It samples the active-low horizontal and vertical sync lines on the pixel clock, realigns a horizontal position counter to each incoming line, and counts lines. Each falling edge of vertical sync is placed within its line. If it lands close to the line boundary, it opens field one and restarts the line count. If it lands close to mid-line, it opens field two. If it lands anywhere else, it is rejected and flagged.

The block also measures how many lines each frame holds. It switches its standard flag between the short-frame and the long-frame standard only when two frames in a row agree. All lengths are parameters. With the defaults, a line is 1716 clocks (858 luma samples at twice the rate), and the two frame totals are 525 and 625 lines. The outputs drive the video timing logic downstream, which is not part of this block.

Top module: `slave_field_detect`

## Requirements
- R1: A sync input is registered on the rising clock edge. `h_count` becomes 1 on the second rising edge after the edge that first samples HSYNC low. Otherwise `h_count` increments by one per clock and saturates at its maximum.
- R2: On the edge where `h_count` returns to 1, `line_count` increments by one, unless a field-one start is taken on that same edge.
- R3: The line length L is the value `h_count` held on the clock where it was restarted, and it resets to LINE_NOM. The position h of a VSYNC fall is the number of clocks from the sampled HSYNC fall to the sampled VSYNC fall, with h = L when the two coincide. With Q = floor(L/4) and M = floor(L/2), the boundary window is h < Q or h > L-Q, and the mid window is M-Q < h < M+Q.
- R4: A VSYNC fall in the boundary window is a field-one start. Two edges after it is sampled, `field_two` goes to 0 and `field_start` pulses for one cycle. `line_count` becomes 1, or 0 when h > L-Q and no HSYNC fall coincides, so that the next line is line 1.
- R5: A VSYNC fall in the mid window, and not in the boundary window, is a field-two start. `field_two` goes to 1 and `field_start` pulses for one cycle, with the same timing as in R4. `line_count` is not changed.
- R6: A VSYNC fall outside both windows is ignored: there is no `field_start`, and neither `field_two` nor `line_count` changes. It sets `win_err`, which stays at 1 until reset.
- R7: At each field-one start, the frame total is `line_count` when h > L-Q, and `line_count - 1` otherwise. `std_625` changes only at a field-one start, and only when this total equals the previous one and is either LINES_A (flag set to 0) or LINES_B (flag set to 1). In every other case the flag holds its value.
- R8: While reset is asserted, the outputs read: `h_count` 0, `line_count` 0, `field_two` 0, `field_start` 0, `std_625` 0, `win_err` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hsync_n | input | 1 | External horizontal sync, active low |
| vsync_n | input | 1 | External vertical sync, active low |
| h_count | output | H_W | Position in the line, 1 at line start |
| line_count | output | V_W | Line number within the frame |
| field_two | output | 1 | 0 in field one, 1 in field two |
| field_start | output | 1 | One-cycle pulse when a field start is accepted |
| std_625 | output | 1 | 0 for the LINES_A standard, 1 for LINES_B |
| win_err | output | 1 | Sticky flag for a VSYNC fall outside both windows |

## Verification
The hardest situations to reach are the ones at the edges of the windows, and the ones where VSYNC falls just before the line boundary rather than just after it.

The stimulus uses a short line length, so each window edge can be hit with an exact offset: the two error positions at Q and L-Q, the coincident fall, and the early fall that parks `line_count` at 0. Lines of a second length move the windows themselves. Whole frames of alternating totals check that the standard flag changes only on the second matching frame.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic {
    FLD_ONE = 1'b0,
    FLD_TWO = 1'b1
  } field_e;
endpackage

// File: rtl/fd_edge.sv
module fd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic fall_q
);
  logic s1_q, s2_q, fall_nx;

  always_comb fall_nx = s2_q & ~s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      s1_q   <= sync_n;
      s2_q   <= s1_q;
      fall_q <= fall_nx;
    end
  end

  // R1: a detected fall is a single-cycle event
  a_r1_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q);
endmodule

// File: rtl/fd_hcount.sv
module fd_hcount #(
  parameter int H_W      = 12,
  parameter int LINE_NOM = 1716
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hfall,
  output logic [H_W-1:0] h_count,
  output logic [H_W-1:0] line_len
);
  localparam logic [H_W-1:0] H_MAX = {H_W{1'b1}};
  localparam logic [H_W-1:0] H_ONE = H_W'(1);

  logic [H_W-1:0] h_nx;
  logic           len_en;

  always_comb begin
    len_en = hfall;
    if (hfall)                 h_nx = H_ONE;
    else if (h_count == H_MAX) h_nx = h_count;
    else                       h_nx = h_count + H_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_count  <= '0;
      line_len <= H_W'(LINE_NOM);
    end else begin
      h_count <= h_nx;
      if (len_en) line_len <= h_count;
    end
  end

  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hfall |=> h_count == H_ONE);
  a_r3_len_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hfall |=> line_len == $past(h_count));
endmodule

// File: rtl/fd_classify.sv
module fd_classify
  import fd_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hfall,
  input  logic           vfall,
  input  logic [H_W-1:0] h_count,
  input  logic [H_W-1:0] line_len,
  output logic [V_W-1:0] line_count,
  output logic           field_two,
  output logic           field_start,
  output logic           win_err,
  output logic           frame_evt,
  output logic [V_W-1:0] frame_total
);
  localparam logic [V_W-1:0] V_ONE = V_W'(1);

  logic [H_W-1:0] qtr, half;
  logic           in_start, in_mid, early, ev_one, ev_two, ev_bad;
  logic [V_W-1:0] line_nx;
  field_e         fld_q, fld_nx;
  logic           fs_nx, err_nx;

  always_comb begin
    qtr      = line_len >> 2;
    half     = line_len >> 1;
    early    = h_count > (line_len - qtr);
    in_start = (h_count < qtr) || early;
    in_mid   = (h_count > (half - qtr)) && (h_count < (half + qtr));
    ev_one   = vfall & in_start;
    ev_two   = vfall & ~in_start & in_mid;
    ev_bad   = vfall & ~in_start & ~in_mid;

    frame_evt   = ev_one;
    frame_total = early ? line_count : (line_count - V_ONE);

    if (ev_one)     line_nx = (early && !hfall) ? '0 : V_ONE;
    else if (hfall) line_nx = line_count + V_ONE;
    else            line_nx = line_count;

    if (ev_one)      fld_nx = FLD_ONE;
    else if (ev_two) fld_nx = FLD_TWO;
    else             fld_nx = fld_q;

    fs_nx  = ev_one | ev_two;
    err_nx = win_err | ev_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_count  <= '0;
      fld_q       <= FLD_ONE;
      field_start <= 1'b0;
      win_err     <= 1'b0;
    end else begin
      line_count  <= line_nx;
      fld_q       <= fld_nx;
      field_start <= fs_nx;
      win_err     <= err_nx;
    end
  end

  always_comb field_two = (fld_q == FLD_TWO);

  a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hfall && !vfall) |=> line_count == $past(line_count) + V_ONE);
  a_r4_f1_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> (line_count <= V_ONE) && !field_two && field_start);
  a_r4_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !field_start);
  a_r5_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (vfall && !frame_evt && !hfall) |=> $stable(line_count));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |=> win_err);
endmodule

// File: rtl/fd_stdsel.sv
module fd_stdsel #(
  parameter int V_W     = 10,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_evt,
  input  logic [V_W-1:0] frame_total,
  output logic           std_b
);
  localparam logic [V_W-1:0] TOT_A = V_W'(LINES_A);
  localparam logic [V_W-1:0] TOT_B = V_W'(LINES_B);

  logic [V_W-1:0] prev_q;
  logic           match, std_nx;

  always_comb begin
    match  = frame_evt && (frame_total == prev_q) &&
             ((frame_total == TOT_A) || (frame_total == TOT_B));
    std_nx = match ? (frame_total == TOT_B) : std_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      std_b  <= 1'b0;
    end else begin
      if (frame_evt) prev_q <= frame_total;
      std_b <= std_nx;
    end
  end

  a_r7_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_evt |=> $stable(std_b));
endmodule

// File: rtl/slave_field_detect.sv
module slave_field_detect #(
  parameter int H_W      = 12,
  parameter int V_W      = 10,
  parameter int LINE_NOM = 1716,
  parameter int LINES_A  = 525,
  parameter int LINES_B  = 625
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hsync_n,
  input  logic           vsync_n,
  output logic [H_W-1:0] h_count,
  output logic [V_W-1:0] line_count,
  output logic           field_two,
  output logic           field_start,
  output logic           std_625,
  output logic           win_err
);
  localparam int N_SYNC = 2;

  logic              rst_meta_q, rst_s_q;
  logic [N_SYNC-1:0] sync_in, sync_fall;
  logic [H_W-1:0]    line_len;
  logic              frame_evt;
  logic [V_W-1:0]    frame_total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  always_comb sync_in = {vsync_n, hsync_n};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_edge
    fd_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_s_q),
      .sync_n (sync_in[g]),
      .fall_q (sync_fall[g])
    );
  end

  fd_hcount #(.H_W(H_W), .LINE_NOM(LINE_NOM)) u_hcount (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .hfall    (sync_fall[0]),
    .h_count  (h_count),
    .line_len (line_len)
  );

  fd_classify #(.H_W(H_W), .V_W(V_W)) u_classify (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .hfall       (sync_fall[0]),
    .vfall       (sync_fall[1]),
    .h_count     (h_count),
    .line_len    (line_len),
    .line_count  (line_count),
    .field_two   (field_two),
    .field_start (field_start),
    .win_err     (win_err),
    .frame_evt   (frame_evt),
    .frame_total (frame_total)
  );

  fd_stdsel #(.V_W(V_W), .LINES_A(LINES_A), .LINES_B(LINES_B)) u_stdsel (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .frame_evt   (frame_evt),
    .frame_total (frame_total),
    .std_b       (std_625)
  );
endmodule

// File: tb/slave_field_detect_bench.sv
`timescale 1ns/100ps
module slave_field_detect_bench;
  localparam int H_W = 12, V_W = 10, LNOM = 40, LA = 5, LB = 7;

  logic           clk = 1'b0, rst_n = 1'b0, hsync_n = 1'b1, vsync_n = 1'b1;
  logic [H_W-1:0] h_count;
  logic [V_W-1:0] line_count;
  logic           field_two, field_start, std_625, win_err;

  int checks = 0, fails = 0, fs_cnt = 0;
  int hc2, hc3, lc2, lc3;
  bit done = 0;

  always #2.5 clk = ~clk;

  slave_field_detect #(.H_W(H_W), .V_W(V_W), .LINE_NOM(LNOM),
                       .LINES_A(LA), .LINES_B(LB)) u_slave_field_detect (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .h_count(h_count), .line_count(line_count), .field_two(field_two),
    .field_start(field_start), .std_625(std_625), .win_err(win_err));

  always @(negedge clk) if (field_start) fs_cnt++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_line(int len, int vpos);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 2) begin hc2 = int'(h_count); lc2 = int'(line_count); end
      if (i == 3) begin hc3 = int'(h_count); lc3 = int'(line_count); end
      hsync_n = (i < 4) ? 1'b0 : 1'b1;
      vsync_n = (vpos >= 0 && i >= vpos && i < vpos + 3) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic frame(int n);
    run_line(LNOM, 2);
    for (int k = 1; k < n; k++) run_line(LNOM, -1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 h_count", int'(h_count), 0);
    chk("R8 line_count", int'(line_count), 0);
    chk("R8 field_two", int'(field_two), 0);
    chk("R8 field_start", int'(field_start), 0);
    chk("R8 std_625", int'(std_625), 0);
    chk("R8 win_err", int'(win_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_lines();
    run_line(LNOM, -1);
    chk("R1 restart to 1", hc3, 1);
    chk("R2 first line", lc3, 1);
    chk("R1 increment", int'(h_count), 37);
    run_line(LNOM, -1);
    chk("R1 value before restart", hc2, LNOM);
    chk("R2 second line", lc3, 2);
  endtask

  task automatic t_fields();
    int f0;
    f0 = fs_cnt;
    run_line(LNOM, 20);
    chk("R5 field_two set", int'(field_two), 1);
    chk("R5 pulse", fs_cnt - f0, 1);
    chk("R5 line kept", int'(line_count), 3);
    run_line(LNOM, 2);
    chk("R2 pre-reset count", lc3, 4);
    chk("R4 field one", int'(field_two), 0);
    chk("R4 line to 1", int'(line_count), 1);
    chk("R4 pulse", fs_cnt - f0, 2);
    run_line(LNOM, 20);
    run_line(LNOM, 37);
    run_line(LNOM, -1);
    chk("R4 early start parks 0", lc2, 0);
    chk("R4 early next line 1", lc3, 1);
    chk("R4 early field one", int'(field_two), 0);
    chk("R4 early pulse", fs_cnt - f0, 4);
    run_line(LNOM, 0);
    chk("R4 coincident line 1", lc3, 1);
    chk("R4 coincident pulse", fs_cnt - f0, 5);
  endtask

  task automatic t_adapt();
    int f0;
    run_line(48, -1);
    f0 = fs_cnt;
    run_line(48, 10);
    chk("R3 window follows length", fs_cnt - f0, 1);
    chk("R3 no error", int'(win_err), 0);
  endtask

  task automatic t_std();
    frame(LA); frame(LA); frame(LB); frame(LB);
    chk("R7 one long frame keeps flag", int'(std_625), 0);
    frame(LA);
    chk("R7 two long frames set flag", int'(std_625), 1);
    frame(LA);
    chk("R7 one short frame keeps flag", int'(std_625), 1);
    frame(LA);
    chk("R7 two short frames clear flag", int'(std_625), 0);
  endtask

  task automatic t_error();
    int f0, l0;
    run_line(LNOM, 20);
    f0 = fs_cnt; l0 = int'(line_count);
    run_line(LNOM, 10);
    chk("R6 err at quarter", int'(win_err), 1);
    chk("R6 no pulse", fs_cnt - f0, 0);
    chk("R6 field kept", int'(field_two), 1);
    chk("R6 line not reset", int'(line_count), l0 + 1);
    run_line(LNOM, 30);
    chk("R6 no pulse at L-Q", fs_cnt - f0, 0);
    chk("R6 line not reset at L-Q", int'(line_count), l0 + 2);
    run_line(LNOM, 2);
    chk("R6 err sticky", int'(win_err), 1);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_lines();
    t_fields();
    t_adapt();
    t_std();
    t_error();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule